// File: doc/BRIEF.md
# Pulse Length Down-Counter with Prescaler

This block is the timing unit of an infrared-style remote-control interface. It holds one 8-bit down-counter. The count enable comes from a free-running divider on the peripheral clock, and a 4-bit code picks a power-of-two division ratio. Software loads the counter through a small register port. The counter then steps down once per enable pulse until it reaches zero. At zero it stops and raises an underflow flag.

The counter has two uses, chosen by a mode bit.

- **Transmit mode:** software writes a symbol's pulse width. The underflow flag tells it when to load the next width.
- **Receive mode:** a two-flop synchronizer and an edge detector watch the serial input line. A selected edge sets an edge flag. Software presets the counter to 0xff at one edge and reads it at the next. The pulse length is 0xff minus the value read. If a pulse outlasts the counter range, the counter reaches zero, stops there and raises underflow.

Register map, by `wr_addr`/`rd_addr`:

| Address | Contents |
|---|---|
| 0 | Counter value |
| 1 | Clock select code, bits [3:0] |
| 2 | Mode in bit 0 (0 = transmit, 1 = receive); edge select in bits [2:1] |
| 3 | Flags: bit 0 underflow, bit 1 edge. Reads return the flags; writing 1 to a bit clears it. |

Edge select: bit 1 enables rising edges and bit 2 enables falling edges.

Top module: `pulse_len_timer`

## Requirements
- R1: After reset the counter reads 0, the select code reads 0, the mode reads transmit with both edge enables off, and both flags read 0.
- R2: A write to address 0 loads the counter in that clock edge. The load takes priority over a count enable in the same edge.
- R3: For select code n from 0 to 14, count enables come exactly every 2^n clocks, and each one lowers a nonzero counter by one. After a load, the first enable arrives within 1 to 2^n clocks.
- R4: Select code 15 produces no count enable, so a loaded counter keeps its value.
- R5: When an enable takes the counter from 1 to 0, the underflow flag sets in that same edge and the counter stays at 0 until the next load. Loading 0 does not set the flag.
- R6: Both flags are sticky until software writes 1 to their bit at address 3. If a flag is being set in the same edge as its clear, the set takes priority.
- R7: In receive mode, a rising input edge sets the edge flag when address-2 bit 1 is set, and a falling edge sets it when bit 2 is set. The flag appears on the third clock edge after the input changes.
- R8: In transmit mode, input edges never set the edge flag.
- R9: With select code 0, a counter preset to 0xff reads 0xff minus N, N clocks after the load. This gives the received pulse length.
- R10: In receive mode, a pulse longer than the count range takes the counter to 0. The counter stays there and the underflow flag sets.
- R11: Output `irq_underflow` equals the underflow flag, and output `irq_edge` equals the edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rx_in | input | 1 | Serial receive input, asynchronous |
| irq_underflow | output | 1 | Underflow interrupt flag |
| irq_edge | output | 1 | Receive edge interrupt flag |

## Verification
The bench sweeps every select code. For each code it logs the cycles in which the counter value changes and requires a spacing of exactly 2^n. A divider tapped at the wrong bit, or off by one in its rollover test, would show up as a wrong spacing. Code 15 is held for a long window to catch a reserved code that aliases onto a real divider tap.

The bench also lines up a load with an enable, and an underflow with a flag clear. A design that lets the enable win would read one below the written value. A design that lets the clear win would lose an interrupt. Each edge-select setting is driven with both input polarities, in both modes. This catches swapped edge polarities, missing transmit-mode gating and a synchronizer of the wrong depth, which moves the flag off its expected cycle.

// File: rtl/plt_pkg.sv
package plt_pkg;

  localparam int unsigned PLT_CNT_W = 8;
  localparam int unsigned PLT_SEL_W = 4;
  localparam int unsigned PLT_DIV_W = 14;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CLKSEL = 2'd1,
    REG_CTRL = 2'd2,
    REG_FLAGS = 2'd3
  } reg_addr_e;

  typedef enum logic {
    MODE_TX = 1'b0,
    MODE_RX = 1'b1
  } dir_mode_e;

  typedef struct packed {
    logic fall_en;
    logic rise_en;
  } edge_sel_t;

  // Enable pulse for select code sel: the low sel bits of the divider are all ones.
  // Codes past the divider width give no pulse.
  function automatic logic div_tick(input logic [PLT_DIV_W-1:0] div,
                                    input logic [PLT_SEL_W-1:0] sel);
    logic ok;
    ok = (32'(sel) <= PLT_DIV_W);
    for (int i = 0; i < PLT_DIV_W; i++) begin
      if ((i < 32'(sel)) && !div[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Next counter value. A load wins; a zero counter holds.
  function automatic logic [PLT_CNT_W-1:0] next_count(input logic [PLT_CNT_W-1:0] cur,
                                                      input logic load,
                                                      input logic [PLT_CNT_W-1:0] val,
                                                      input logic tick);
    if (load) return val;
    if (tick && (cur != '0)) return cur - 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/plt_prescaler.sv
module plt_prescaler
  import plt_pkg::*;
#(
  parameter int unsigned DIV_W = PLT_DIV_W,
  parameter int unsigned SEL_W = PLT_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    tick = div_tick(PLT_DIV_W'(div_q), PLT_SEL_W'(sel));
  end

endmodule

// File: rtl/plt_edge_detect.sv
module plt_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] sh_q;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/plt_down_counter.sv
module plt_down_counter
  import plt_pkg::*;
#(
  parameter int unsigned CNT_W = PLT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             uf_event
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(next_count(PLT_CNT_W'(cnt_q), load, PLT_CNT_W'(load_val), tick));
  end

  assign uf_event = tick && !load && (cnt_q == CNT_W'(1));
  assign cnt = cnt_q;

endmodule

// File: rtl/pulse_len_timer.sv
module pulse_len_timer
  import plt_pkg::*;
#(
  parameter int unsigned CNT_W = PLT_CNT_W,
  parameter int unsigned SEL_W = PLT_SEL_W,
  parameter int unsigned DIV_W = PLT_DIV_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             rx_in,
  output logic             irq_underflow,
  output logic             irq_edge
);

  localparam int unsigned PAD_SEL = CNT_W - SEL_W;
  localparam int unsigned PAD_CTRL = CNT_W - 3;
  localparam int unsigned PAD_FLAG = CNT_W - 2;

  logic [SEL_W-1:0] sel_q;
  dir_mode_e        mode_q;
  edge_sel_t        esel_q;
  logic             uf_q;
  logic             ef_q;

  // Named internal events
  logic             cnt_tick;
  logic             cnt_load;
  logic             uf_event;
  logic             in_rise;
  logic             in_fall;
  logic             edge_event;
  logic             uf_clr;
  logic             ef_clr;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_load = wr_en && (wr_addr == REG_COUNT);
  assign uf_clr   = wr_en && (wr_addr == REG_FLAGS) && wr_data[0];
  assign ef_clr   = wr_en && (wr_addr == REG_FLAGS) && wr_data[1];

  plt_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel_q),
    .tick (cnt_tick)
  );

  plt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(wr_data),
    .tick    (cnt_tick),
    .cnt     (cnt_q),
    .uf_event(uf_event)
  );

  plt_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_in),
    .rise (in_rise),
    .fall (in_fall)
  );

  assign edge_event = (mode_q == MODE_RX) &&
                      ((in_rise && esel_q.rise_en) || (in_fall && esel_q.fall_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= MODE_TX;
      esel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_CLKSEL) sel_q <= wr_data[SEL_W-1:0];
      if (wr_addr == REG_CTRL) begin
        mode_q <= dir_mode_e'(wr_data[0]);
        esel_q <= edge_sel_t'(wr_data[2:1]);
      end
    end
  end

  // A set in the same edge wins over a clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q <= 1'b0;
      ef_q <= 1'b0;
    end else begin
      uf_q <= uf_event | (uf_q & ~uf_clr);
      ef_q <= edge_event | (ef_q & ~ef_clr);
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      REG_COUNT:  rd_data = cnt_q;
      REG_CLKSEL: rd_data = {{PAD_SEL{1'b0}}, sel_q};
      REG_CTRL:   rd_data = {{PAD_CTRL{1'b0}}, esel_q, mode_q};
      REG_FLAGS:  rd_data = {{PAD_FLAG{1'b0}}, ef_q, uf_q};
      default:    rd_data = '0;
    endcase
  end

  assign irq_underflow = uf_q;
  assign irq_edge      = ef_q;

endmodule

// File: rtl/plt_checker.sv
module plt_checker #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_q,
  input logic             mode_q,
  input logic             cnt_tick,
  input logic             cnt_load,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq_underflow,
  input logic             irq_edge
);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q == $past(wr_data)); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !cnt_load) |=> $stable(cnt_q)); // R3

  AST_SEL0_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> cnt_tick); // R3

  AST_RESERVED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '1) |-> !cnt_tick); // R4

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !cnt_load) |=> cnt_q == '0); // R5

  AST_UF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && cnt_tick && !cnt_load) |=> irq_underflow); // R5

  AST_TX_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !irq_edge) |=> !irq_edge); // R8

endmodule

bind pulse_len_timer plt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_plt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_q        (sel_q),
  .mode_q       (mode_q),
  .cnt_tick     (cnt_tick),
  .cnt_load     (cnt_load),
  .wr_data      (wr_data),
  .cnt_q        (cnt_q),
  .irq_underflow(irq_underflow),
  .irq_edge     (irq_edge)
);

// File: tb/tb_pulse_len_timer.sv
module tb_pulse_len_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rx_in = 1'b0;
  logic       irq_underflow;
  logic       irq_edge;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_len_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_in(rx_in),
    .irq_underflow(irq_underflow), .irq_edge(irq_edge)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge, returns at the following negedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int prev;
    int t;
    int last_t;
    int nchg;
    int first_t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 irq_underflow reset", int'(irq_underflow), 0);
    chk("R1 irq_edge reset", int'(irq_edge), 0);

    // R2: with code 0 every edge is an enable, so the loaded value must appear intact.
    wr(2'd0, 8'd77);
    rd(2'd0, v);
    chk("R2 load over tick", v, 77);

    // R9: preset 0xff and count N clocks with code 0.
    for (int n = 1; n <= 40; n += 13) begin
      wr(2'd0, 8'hff);
      idle(n);
      rd(2'd0, v);
      chk("R9 measured length", v, 255 - n);
    end

    // R5: load 0 sets no flag.
    wr(2'd3, 8'h3);
    wr(2'd0, 8'd0);
    idle(3);
    rd(2'd3, v);
    chk("R5 zero load no flag", v & 1, 0);

    // R3 / R5: sweep every code, exact spacing of 2^n.
    for (int n = 0; n <= 14; n++) begin
      int ld;
      ld = (n < 10) ? 4 : 2;
      wr(2'd1, 8'(n));
      wr(2'd3, 8'h1);
      wr(2'd0, 8'(ld));
      prev = ld; t = 0; nchg = 0; last_t = 0; first_t = 0;
      while (prev != 0 && t < 40000) begin
        @(negedge clk);
        t++;
        rd(2'd0, v);
        if (v != prev) begin
          chk("R3 step of one", v, prev - 1);
          if (nchg == 0) first_t = t;
          else chk("R3 enable spacing", t - last_t, 1 << n);
          last_t = t;
          nchg++;
          prev = v;
          if (v == 0) chk("R5 flag with zero", int'(irq_underflow), 1);
          else        chk("R5 no early flag", int'(irq_underflow), 0);
        end
      end
      chk("R3 first enable in window", int'(first_t >= 1 && first_t <= (1 << n)), 1);
      chk("R3 all steps seen", nchg, ld);
      idle(3 << n > 50 ? 50 : 3 << n);
      rd(2'd0, v);
      chk("R5 halts at zero", v, 0);
      chk("R11 irq mirrors flag", int'(irq_underflow), 1);
    end

    // R4: reserved code freezes the counter.
    wr(2'd1, 8'hf);
    wr(2'd0, 8'd9);
    idle(20000);
    rd(2'd0, v);
    chk("R4 reserved code holds", v, 9);

    // R6: sticky, and set wins over a clear in the same edge.
    wr(2'd1, 8'h0);
    wr(2'd3, 8'h1);
    rd(2'd3, v);
    chk("R6 cleared", v & 1, 0);
    wr(2'd0, 8'd1);
    wr(2'd3, 8'h1);
    rd(2'd3, v);
    chk("R6 set beats clear", v & 1, 1);
    idle(10);
    chk("R6 sticky", int'(irq_underflow), 1);
    wr(2'd3, 8'h2);
    chk("R6 other bit write keeps flag", int'(irq_underflow), 1);

    // R10: overlong receive pulse.
    wr(2'd2, 8'h7);
    wr(2'd3, 8'h3);
    wr(2'd0, 8'hff);
    idle(300);
    rd(2'd0, v);
    chk("R10 overlong halts", v, 0);
    chk("R10 overlong flag", int'(irq_underflow), 1);

    // R7 / R8: every edge select in both modes, both polarities.
    // CTRL bit0 mode, bit1 rising enable, bit2 falling enable.
    for (int m = 0; m < 2; m++) begin
      for (int es = 0; es < 4; es++) begin
        for (int pol = 0; pol < 2; pol++) begin
          rx_in = 1'b1 ^ pol[0];
          idle(6);
          wr(2'd2, 8'((es << 1) | m));
          wr(2'd3, 8'h2);
          rx_in = pol[0];
          @(negedge clk); @(negedge clk);
          chk("R7 not before third edge", int'(irq_edge), 0);
          @(negedge clk);
          if (m == 1) chk("R7 edge select", int'(irq_edge), (pol == 0) ? ((es >> 1) & 1) : (es & 1));
          else        chk("R8 tx ignores edges", int'(irq_edge), 0);
          rd(2'd3, v);
          chk("R11 irq_edge matches flag", int'(irq_edge), (v >> 1) & 1);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule